// File: doc/BRIEF.md
# LCD Frame-End Interrupt Generator

This block follows the vertical timing of an LCD refresh engine. It counts line strobes against a programmed number of visible lines and blanking lines. When the last visible line of a frame completes and vertical blanking begins, it sets a frame-end flag. The flag is sticky. Software clears it by writing a one to it, and a written zero leaves it unchanged.

The flag sets at every frame end, whatever the enables hold. The level interrupt sent to the interrupt controller is the flag qualified by an interrupt enable bit. A separate DMA enable lets the same frame-end event send a one-clock request to a DMA engine, which can then refill display memory during blanking. Software should clear the flag before it sets the interrupt enable, so that an old event does not raise the interrupt at once. When the panel-type select chooses a TFT-style interface, the block produces no frame-end events at all.

The block assumes that the line strobe is a one-clock pulse, that at least one visible line is programmed, and that at least one blanking line is programmed. The frame strobe puts the line count back to the first visible line.

Top module: `lcd_frame_irq`

## Requirements
- R1: After a synchronous active-low reset, the flag, the interrupt output, the DMA request and both enable bits read 0, and the line count starts at visible line 0.
- R2: The flag becomes 1 on the clock edge at which a line strobe arrives while the count sits on the last visible line (index `disp_lines`-1). This happens whether or not either enable bit is set.
- R3: Once set, the flag stays 1 until a clear write (`clr_we`=1) carries `clr_data`=1. A clear write with `clr_data`=0 has no effect on the flag.
- R4: If a clear write with `clr_data`=1 and a frame-end event happen on the same edge, the flag ends up 1.
- R5: `irq_out` is 1 exactly when the flag is 1, the interrupt enable is 1 and `panel_tft` is 0.
- R6: While `panel_tft`=1, no frame-end event occurs. The flag is not set, no DMA request is issued, and `irq_out` is 0.
- R7: The line count wraps to visible line 0 after `disp_lines`+`blank_lines` strobes. The next frame end therefore comes exactly that many strobes after the previous one.
- R8: A `frame_stb` pulse returns the line count to visible line 0. The following frame end needs `disp_lines` further strobes.
- R9: `dma_req` is 1 for exactly the one cycle after the edge that registers a frame-end event, and only when the DMA enable is 1. With the DMA enable at 0 it stays 0.
- R10: A write with `ctrl_we`=1 loads `ctrl_irq_en` and `ctrl_dma_en` into the enable bits. The loaded values appear on `irq_en_q` and `dma_en_q` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-clock pulse at the end of each line |
| frame_stb | input | 1 | One-clock pulse that restarts the frame at visible line 0 |
| panel_tft | input | 1 | 1 selects a TFT-style panel and suppresses frame-end events |
| disp_lines | input | LINE_W | Number of visible lines per frame |
| blank_lines | input | LINE_W | Number of blanking lines per frame |
| ctrl_we | input | 1 | Write strobe for the enable bits |
| ctrl_irq_en | input | 1 | Interrupt enable value to write |
| ctrl_dma_en | input | 1 | DMA enable value to write |
| clr_we | input | 1 | Write strobe for the flag |
| clr_data | input | 1 | 1 clears the flag, 0 leaves it unchanged |
| irq_en_q | output | 1 | Current interrupt enable |
| dma_en_q | output | 1 | Current DMA enable |
| frame_flag | output | 1 | Sticky frame-end flag |
| irq_out | output | 1 | Level interrupt to the interrupt controller |
| dma_req | output | 1 | One-clock DMA start request |

## Verification
Every result is registered one clock edge after the stimulus that causes it. The flag and the DMA request change on the rising edge that samples the line strobe at the boundary, and the enable bits change on the edge that samples `ctrl_we`. The interrupt output follows the flag and enable bits with no further delay, and `panel_tft` acts on it at once. Stimulus is driven on falling edges and results are read on the next falling edge, so each check falls in the half cycle after the edge that registered the result. The DMA request is then read again one cycle later to confirm that it was a single-cycle pulse.

// File: rtl/lcd_fi_pkg.sv
// Shared definitions for the LCD frame-end interrupt generator.
// Holds the default line-count width and the packed enable-register type.
package lcd_fi_pkg;

    localparam int LINE_W_DEF = 10;

    typedef struct packed {
        logic irq_en;
        logic dma_en;
    } fi_ctrl_t;

endpackage

// File: rtl/lcd_fi_line_ctr.sv
// Vertical line counter and boundary detector.
// Counts line strobes across the visible and blanking lines of a frame and
// emits a one-cycle pulse when the last visible line ends.
// Assumes line_stb is a one-clock pulse and disp_lines >= 1.
module lcd_fi_line_ctr #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              frame_stb,
    input  logic [LINE_W-1:0] disp_lines,
    input  logic [LINE_W-1:0] blank_lines,
    output logic              vis_end
);
    localparam int CNT_W = LINE_W + 1;

    logic [CNT_W-1:0] line_idx;
    logic [CNT_W-1:0] total_lines;
    logic [CNT_W-1:0] last_vis;

    // Derive the frame length and the index of the last visible line.
    always_comb begin
        total_lines = {1'b0, disp_lines} + {1'b0, blank_lines};
        last_vis    = {1'b0, disp_lines} - CNT_W'(1);
    end

    // Track the current line; the frame strobe restarts at line 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_idx <= '0;
        end else if (frame_stb) begin
            line_idx <= '0;
        end else if (line_stb) begin
            if (line_idx >= total_lines - CNT_W'(1)) begin
                line_idx <= '0;
            end else begin
                line_idx <= line_idx + CNT_W'(1);
            end
        end
    end

    // Flag the strobe that leaves the visible area.
    always_comb begin
        vis_end = line_stb && !frame_stb && (disp_lines != '0) && (line_idx == last_vis);
    end

endmodule

// File: rtl/lcd_fi_flag.sv
// Enable register, sticky frame-end flag and level interrupt.
// A frame-end event has priority over a clear write on the same edge.
// Assumes evt is already qualified by the panel type.
module lcd_fi_flag
    import lcd_fi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     evt,
    input  logic     ctrl_we,
    input  fi_ctrl_t ctrl_wdata,
    input  logic     clr_we,
    input  logic     clr_data,
    input  logic     panel_tft,
    output fi_ctrl_t ctrl_q,
    output logic     flag,
    output logic     irq
);

    // Hold the enable bits loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_wdata;
        end
    end

    // Sticky flag: set on the event, cleared only by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (evt) begin
            flag <= 1'b1;
        end else if (clr_we && clr_data) begin
            flag <= 1'b0;
        end
    end

    // Qualify the flag for the interrupt controller.
    always_comb begin
        irq = flag && ctrl_q.irq_en && !panel_tft;
    end

endmodule

// File: rtl/lcd_fi_dma.sv
// One-clock DMA start request registered from the frame-end event.
// Assumes events never arrive on two consecutive cycles.
module lcd_fi_dma (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic dma_en,
    output logic dma_req
);

    // Register the event when the DMA enable allows it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_req <= 1'b0;
        end else begin
            dma_req <= evt && dma_en;
        end
    end

endmodule

// File: rtl/lcd_frame_irq.sv
// Top of the LCD frame-end interrupt generator.
// Detects the end of the visible area, suppresses it for TFT-style panels,
// and drives the sticky flag, the level interrupt and the DMA request.
module lcd_frame_irq
    import lcd_fi_pkg::*;
#(
    parameter int LINE_W = LINE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              frame_stb,
    input  logic              panel_tft,
    input  logic [LINE_W-1:0] disp_lines,
    input  logic [LINE_W-1:0] blank_lines,
    input  logic              ctrl_we,
    input  logic              ctrl_irq_en,
    input  logic              ctrl_dma_en,
    input  logic              clr_we,
    input  logic              clr_data,
    output logic              irq_en_q,
    output logic              dma_en_q,
    output logic              frame_flag,
    output logic              irq_out,
    output logic              dma_req
);
    logic     vis_end;
    logic     frame_end;
    fi_ctrl_t ctrl_wdata;
    fi_ctrl_t ctrl_q;

    lcd_fi_line_ctr #(.LINE_W(LINE_W)) u_line_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_stb   (line_stb),
        .frame_stb  (frame_stb),
        .disp_lines (disp_lines),
        .blank_lines(blank_lines),
        .vis_end    (vis_end)
    );

    // Gate the boundary with the panel type and pack the write data.
    always_comb begin
        frame_end         = vis_end && !panel_tft;
        ctrl_wdata.irq_en = ctrl_irq_en;
        ctrl_wdata.dma_en = ctrl_dma_en;
    end

    lcd_fi_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (frame_end),
        .ctrl_we   (ctrl_we),
        .ctrl_wdata(ctrl_wdata),
        .clr_we    (clr_we),
        .clr_data  (clr_data),
        .panel_tft (panel_tft),
        .ctrl_q    (ctrl_q),
        .flag      (frame_flag),
        .irq       (irq_out)
    );

    lcd_fi_dma u_dma (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (frame_end),
        .dma_en (ctrl_q.dma_en),
        .dma_req(dma_req)
    );

    // Expose the enable bits.
    always_comb begin
        irq_en_q = ctrl_q.irq_en;
        dma_en_q = ctrl_q.dma_en;
    end

endmodule

// File: rtl/lcd_frame_irq_chk.sv
// Temporal checks for the LCD frame-end interrupt generator, bound to the top.
module lcd_frame_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_end,
    input logic clr_we,
    input logic clr_data,
    input logic panel_tft,
    input logic frame_flag,
    input logic irq_out,
    input logic dma_req
);

    // R2
    set_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> frame_flag);

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_flag && !(clr_we && clr_data)) |=> frame_flag);

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && clr_we && clr_data) |=> frame_flag);

    // R5
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_data && !frame_end) |=> !irq_out);

    // R6
    tft_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_flag && panel_tft) |=> !frame_flag);

    // R9
    dma_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

endmodule

bind lcd_frame_irq lcd_frame_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .clr_we    (clr_we),
    .clr_data  (clr_data),
    .panel_tft (panel_tft),
    .frame_flag(frame_flag),
    .irq_out   (irq_out),
    .dma_req   (dma_req)
);

// File: tb/lcd_frame_irq_bench.sv
`timescale 1ns/1ps
module lcd_frame_irq_bench;
    localparam int LW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_stb = 1'b0;
    logic          frame_stb = 1'b0;
    logic          panel_tft = 1'b0;
    logic [LW-1:0] disp_lines = LW'(4);
    logic [LW-1:0] blank_lines = LW'(3);
    logic          ctrl_we = 1'b0;
    logic          ctrl_irq_en = 1'b0;
    logic          ctrl_dma_en = 1'b0;
    logic          clr_we = 1'b0;
    logic          clr_data = 1'b0;
    logic          irq_en_q, dma_en_q, frame_flag, irq_out, dma_req;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    lcd_frame_irq #(.LINE_W(LW)) u_lcd_frame_irq (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_stb(frame_stb),
        .panel_tft(panel_tft), .disp_lines(disp_lines), .blank_lines(blank_lines),
        .ctrl_we(ctrl_we), .ctrl_irq_en(ctrl_irq_en), .ctrl_dma_en(ctrl_dma_en),
        .clr_we(clr_we), .clr_data(clr_data), .irq_en_q(irq_en_q), .dma_en_q(dma_en_q),
        .frame_flag(frame_flag), .irq_out(irq_out), .dma_req(dma_req)
    );

    // Vector: {disp[7:0], blank[7:0], strobes[7:0], tft, expected flag}
    localparam int NV = 8;
    localparam logic [25:0] VEC [NV] = '{
        {8'd4, 8'd3, 8'd3, 1'b0, 1'b0},
        {8'd4, 8'd3, 8'd4, 1'b0, 1'b1},
        {8'd4, 8'd3, 8'd6, 1'b0, 1'b1},
        {8'd4, 8'd3, 8'd4, 1'b1, 1'b0},
        {8'd2, 8'd1, 8'd1, 1'b0, 1'b0},
        {8'd2, 8'd1, 8'd2, 1'b0, 1'b1},
        {8'd1, 8'd2, 8'd1, 1'b0, 1'b1},
        {8'd6, 8'd2, 8'd5, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) line_stb = 1'b1;
        @(negedge clk) line_stb = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) strobe();
    endtask

    task automatic restart();
        @(negedge clk) frame_stb = 1'b1;
        @(negedge clk) frame_stb = 1'b0;
    endtask

    task automatic clear(input logic d);
        @(negedge clk) begin clr_we = 1'b1; clr_data = d; end
        @(negedge clk) begin clr_we = 1'b0; clr_data = 1'b0; end
    endtask

    task automatic set_en(input logic ie, input logic de);
        @(negedge clk) begin ctrl_we = 1'b1; ctrl_irq_en = ie; ctrl_dma_en = de; end
        @(negedge clk) ctrl_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flag", frame_flag, 1'b0);
        chk("R1 irq", irq_out, 1'b0);
        chk("R1 dma", dma_req, 1'b0);
        chk("R1 irq_en", irq_en_q, 1'b0);
        chk("R1 dma_en", dma_en_q, 1'b0);
        // R1 count begins at line 0: boundary after exactly disp strobes
        strobes(3);
        chk("R1 line0 early", frame_flag, 1'b0);
        strobe();
        chk("R1 line0 boundary", frame_flag, 1'b1);

        // R2 table walk: flag sets at the boundary with both enables off
        for (int v = 0; v < NV; v++) begin
            disp_lines  = LW'(VEC[v][25:18]);
            blank_lines = LW'(VEC[v][17:10]);
            panel_tft   = VEC[v][1];
            clear(1'b1);
            restart();
            strobes(int'(VEC[v][9:2]));
            chk($sformatf("R2 vector %0d", v), frame_flag, VEC[v][0]);
            panel_tft = 1'b0;
        end

        disp_lines  = LW'(4);
        blank_lines = LW'(3);

        // R7 wrap after disp+blank strobes
        clear(1'b1);
        restart();
        strobes(4);
        chk("R7 first end", frame_flag, 1'b1);
        clear(1'b1);
        strobes(6);
        chk("R7 before wrap end", frame_flag, 1'b0);
        strobe();
        chk("R7 second end", frame_flag, 1'b1);

        // R3 write 0 ignored, write 1 clears
        clear(1'b0);
        chk("R3 write zero", frame_flag, 1'b1);
        repeat (3) @(negedge clk);
        chk("R3 sticky idle", frame_flag, 1'b1);
        clear(1'b1);
        chk("R3 write one", frame_flag, 1'b0);

        // R10 enable loading and R5 interrupt gating
        set_en(1'b1, 1'b0);
        chk("R10 irq_en", irq_en_q, 1'b1);
        chk("R10 dma_en", dma_en_q, 1'b0);
        chk("R5 no flag", irq_out, 1'b0);
        restart();
        strobes(4);
        chk("R5 flag and en", irq_out, 1'b1);
        @(negedge clk) panel_tft = 1'b1;
        #1 chk("R5 tft gates irq", irq_out, 1'b0);
        @(negedge clk) panel_tft = 1'b0;
        #1 chk("R5 tft released", irq_out, 1'b1);
        set_en(1'b0, 1'b0);
        chk("R5 en off", irq_out, 1'b0);
        chk("R5 flag kept", frame_flag, 1'b1);

        // R4 set beats clear in the same cycle
        clear(1'b1);
        restart();
        strobes(3);
        @(negedge clk) begin line_stb = 1'b1; clr_we = 1'b1; clr_data = 1'b1; end
        @(negedge clk) begin line_stb = 1'b0; clr_we = 1'b0; clr_data = 1'b0; end
        chk("R4 set wins", frame_flag, 1'b1);

        // R9 DMA pulse
        clear(1'b1);
        set_en(1'b0, 1'b1);
        restart();
        strobes(3);
        chk("R9 no early dma", dma_req, 1'b0);
        strobe();
        chk("R9 dma high", dma_req, 1'b1);
        @(negedge clk);
        chk("R9 dma one cycle", dma_req, 1'b0);
        set_en(1'b0, 1'b0);
        clear(1'b1);
        restart();
        strobes(4);
        chk("R9 dma disabled", dma_req, 1'b0);
        chk("R9 flag still sets", frame_flag, 1'b1);

        // R6 TFT panel suppresses everything
        clear(1'b1);
        set_en(1'b1, 1'b1);
        panel_tft = 1'b1;
        restart();
        strobes(4);
        chk("R6 no dma", dma_req, 1'b0);
        chk("R6 no flag", frame_flag, 1'b0);
        chk("R6 no irq", irq_out, 1'b0);
        panel_tft = 1'b0;
        set_en(1'b0, 1'b0);

        // R8 frame strobe restarts the count
        clear(1'b1);
        restart();
        strobes(2);
        restart();
        strobes(3);
        chk("R8 after restart early", frame_flag, 1'b0);
        strobe();
        chk("R8 after restart end", frame_flag, 1'b1);

        finish_run();
    end
endmodule